// File: doc/BRIEF.md
# Blanking-interval audio embedder

This block lives on the transmit side of a parallel video link and runs on the pixel clock. Every cycle it forms one 27-bit word for the serializer. While data-enable is high, the word carries 18 bits of RGB video. While data-enable is low (blanking), the RGB field is zero. In that case the serializer sends the nine control bits, and spare control bits carry a serial audio stream in I2S form: serial data, word select and, where needed, a bit clock or a chip select.

Audio arrives one bit at a time over a ready/valid handshake. Each beat carries one data bit and one word-select bit. A beat is accepted only in a cycle that actually places it on the link.

Two modes are available. In raw mode the pixel clock is the bit clock. An active-low chip select marks the words that hold a fresh bit and stays high otherwise. In compressed mode the block generates a bit clock on a control bit at 1/2, 1/4 or 1/8 of the pixel rate. Data changes only while that clock is low. Throttling holds the clock low.

Top module: `blank_audio_embedder`

## Requirements
- R1: One cycle after a cycle with de_i high, word_o[17:0] equals the rgb_i of that cycle. In every word whose data-enable bit (bit 20) is low, word_o[17:0] is zero.
- R2: In every mode, word_o bits 18, 19 and 20 hold vsync_i, hsync_i and de_i of the previous cycle.
- R3: word_o bits 25 and 26 hold aux_i[0] and aux_i[1] of the previous cycle.
- R4: While de_i is high, aud_ready_o is low and no audio beat is taken. In compressed mode, bit 23 keeps its level through the active-video cycles.
- R5: In raw mode (mode_i=0), aud_ready_o is high in every blanking cycle. A cycle with aud_valid_i high produces a next word with bit 21 = sd, bit 22 = ws and bit 24 (chip select, active low) = 0.
- R6: In raw mode, a cycle without an accepted beat produces a next word with bit 24 = 1 and bit 23 = 0, and bits 21 and 22 unchanged.
- R7: In compressed mode (mode_i=1), div_sel_i selects the bit-clock period N: 0 gives 2, 1 gives 4, and 2 or 3 give 8 pixel cycles. With beats offered back to back in blanking, bit 23 is low for N/2 words and then high for N/2 words. Each rising edge of bit 23 presents the next offered data bit on bit 21.
- R8: Bits 21 and 22 change only in a word whose bit 23 is low.
- R9: In compressed mode, bit 24 is 0. aud_ready_o rises only at a bit-period boundary in blanking. When no beat is offered there, bit 23 stays low and aud_ready_o stays high.
- R10: div_sel_i is sampled when a bit period starts. A change in the middle of a period takes effect from the next period.
- R11: While rst_n is low, word_o is zero except bit 24, which is 1, and aud_ready_o is low.
- R12: An active-video interval inside a compressed-mode bit period freezes the period. It resumes where it stopped when blanking returns, with no extra rising edge on bit 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 1 | 0 = raw (pixel-clocked, chip-select throttle), 1 = compressed (divided bit clock) |
| div_sel_i | input | 2 | Compressed-mode bit-clock divide select |
| vsync_i | input | 1 | Vertical sync |
| hsync_i | input | 1 | Horizontal sync |
| de_i | input | 1 | Data enable, high during active video |
| rgb_i | input | 18 | Pixel colour, three 6-bit fields |
| aux_i | input | 2 | Side-band bits passed to control bits 7 and 8 |
| aud_valid_i | input | 1 | Audio beat offered |
| aud_sd_i | input | 1 | Audio serial data bit of the beat |
| aud_ws_i | input | 1 | Audio word-select bit of the beat |
| aud_ready_o | output | 1 | Beat accepted in this cycle when valid is high |
| word_o | output | 27 | Registered link word: [17:0] RGB, [26:18] control bits 0 to 8 |

## Verification
The checker watches several properties on every cycle: the one-cycle pass-through of the sync, data-enable, RGB and side bits; zero RGB during blanking; no handshake during active video; the raw-mode chip-select and data behaviour; the compressed-mode chip-select level; data changes only while the bit clock is low; and the held bit-clock level across active video. The testbench scenarios are needed for properties that span many cycles. These are the exact bit-clock period for each divide select, the bit sequence seen at the receiver's rising edges, that a mid-period divide change waits for the next period, and that a period frozen by active video resumes with the correct count of high words.

// File: rtl/emb_pkg.sv
package emb_pkg;

  // control bit positions inside the 9-bit control field (decoded downstream)
  localparam int CTL_W  = 9;
  localparam int C_VS   = 0;
  localparam int C_HS   = 1;
  localparam int C_DE   = 2;
  localparam int C_SD   = 3;
  localparam int C_WS   = 4;
  localparam int C_SCK  = 5;
  localparam int C_CSN  = 6;
  localparam int C_AUX0 = 7;
  localparam int C_AUX1 = 8;

  localparam int DIV_MAX = 8;
  localparam int POS_W   = $clog2(DIV_MAX + 1);

  typedef enum logic {
    MODE_RAW = 1'b0,
    MODE_CMP = 1'b1
  } emb_mode_e;

  // member order puts vs at bit 0 and aux1 at bit 8
  typedef struct packed {
    logic aux1;
    logic aux0;
    logic cs_n;
    logic sck;
    logic ws;
    logic sd;
    logic de;
    logic hs;
    logic vs;
  } ctl_word_t;

  function automatic logic [POS_W-1:0] div_decode(input logic [1:0] sel);
    case (sel)
      2'd0:    return POS_W'(2);
      2'd1:    return POS_W'(4);
      default: return POS_W'(8);
    endcase
  endfunction

endpackage

// File: rtl/emb_rst_sync.sv
module emb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_nxt;
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/emb_bitclk_gen.sv
module emb_bitclk_gen
  import emb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_en,
  input  logic       blank,
  input  logic       valid,
  input  logic [1:0] div_sel,
  output logic       at_boundary,
  output logic       take,
  output logic       sck_nxt
);

  logic [POS_W-1:0] pos_q, pos_nxt;
  logic [POS_W-1:0] div_q, div_nxt;

  always_comb begin
    at_boundary = (pos_q == '0) || (pos_q == div_q);
    take        = cmp_en && blank && valid && at_boundary;
    div_nxt     = take ? div_decode(div_sel) : div_q;

    if (!cmp_en) begin
      pos_nxt = '0;
    end else if (!blank) begin
      pos_nxt = pos_q;
    end else if (take) begin
      pos_nxt = POS_W'(1);
    end else if (at_boundary) begin
      pos_nxt = '0;
    end else begin
      pos_nxt = pos_q + POS_W'(1);
    end

    sck_nxt = pos_nxt > (div_nxt >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      div_q <= div_decode(2'd0);
    end else begin
      pos_q <= pos_nxt;
      div_q <= div_nxt;
    end
  end

endmodule

// File: rtl/emb_audio_slot.sv
module emb_audio_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_en,
  input  logic blank,
  input  logic valid,
  input  logic cmp_take,
  input  logic sd_i,
  input  logic ws_i,
  output logic raw_take,
  output logic sd_nxt,
  output logic ws_nxt,
  output logic cs_n_nxt
);

  logic sd_q, ws_q;
  logic load;

  always_comb begin
    raw_take = raw_en && blank && valid;
    load     = raw_take || cmp_take;
    sd_nxt   = load ? sd_i : sd_q;
    ws_nxt   = load ? ws_i : ws_q;
    cs_n_nxt = raw_en ? !raw_take : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_q <= 1'b0;
      ws_q <= 1'b0;
    end else if (load) begin
      sd_q <= sd_i;
      ws_q <= ws_i;
    end
  end

endmodule

// File: rtl/emb_word_pack.sv
module emb_word_pack
  import emb_pkg::*;
#(
  parameter int RGB_W  = 18,
  parameter int WORD_W = RGB_W + CTL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RGB_W-1:0]  rgb_i,
  input  ctl_word_t         ctl_nxt,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-1:0] word_q, word_nxt;
  logic [RGB_W-1:0]  rgb_sel;

  always_comb begin
    rgb_sel  = ctl_nxt.de ? rgb_i : '0;
    word_nxt = {ctl_nxt, rgb_sel};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q                 <= '0;
      word_q[RGB_W + C_CSN]  <= 1'b1;
    end else begin
      word_q <= word_nxt;
    end
  end

  assign word_o = word_q;

endmodule

// File: rtl/blank_audio_embedder.sv
module blank_audio_embedder
  import emb_pkg::*;
#(
  parameter int  COLOR_W     = 6,
  parameter int  SYNC_STAGES = 2,
  localparam int RGB_W       = 3 * COLOR_W,
  localparam int WORD_W      = RGB_W + CTL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_i,
  input  logic [1:0]        div_sel_i,
  input  logic              vsync_i,
  input  logic              hsync_i,
  input  logic              de_i,
  input  logic [RGB_W-1:0]  rgb_i,
  input  logic [1:0]        aux_i,
  input  logic              aud_valid_i,
  input  logic              aud_sd_i,
  input  logic              aud_ws_i,
  output logic              aud_ready_o,
  output logic [WORD_W-1:0] word_o
);

  logic      rst_sync_n;
  logic      blank;
  logic      raw_en, cmp_en;
  logic      at_boundary, cmp_take, raw_take;
  logic      sck_nxt, sd_nxt, ws_nxt, cs_n_nxt;
  ctl_word_t ctl_nxt;

  emb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    blank  = rst_sync_n && !de_i;
    raw_en = (emb_mode_e'(mode_i) == MODE_RAW);
    cmp_en = (emb_mode_e'(mode_i) == MODE_CMP);
  end

  emb_bitclk_gen u_clkgen (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .cmp_en      (cmp_en),
    .blank       (blank),
    .valid       (aud_valid_i),
    .div_sel     (div_sel_i),
    .at_boundary (at_boundary),
    .take        (cmp_take),
    .sck_nxt     (sck_nxt)
  );

  emb_audio_slot u_slot (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .raw_en   (raw_en),
    .blank    (blank),
    .valid    (aud_valid_i),
    .cmp_take (cmp_take),
    .sd_i     (aud_sd_i),
    .ws_i     (aud_ws_i),
    .raw_take (raw_take),
    .sd_nxt   (sd_nxt),
    .ws_nxt   (ws_nxt),
    .cs_n_nxt (cs_n_nxt)
  );

  always_comb begin
    aud_ready_o  = blank && (raw_en || at_boundary);
    ctl_nxt.vs   = vsync_i;
    ctl_nxt.hs   = hsync_i;
    ctl_nxt.de   = de_i;
    ctl_nxt.sd   = sd_nxt;
    ctl_nxt.ws   = ws_nxt;
    ctl_nxt.sck  = sck_nxt;
    ctl_nxt.cs_n = cs_n_nxt;
    ctl_nxt.aux0 = aux_i[0];
    ctl_nxt.aux1 = aux_i[1];
  end

  emb_word_pack #(.RGB_W(RGB_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rgb_i   (rgb_i),
    .ctl_nxt (ctl_nxt),
    .word_o  (word_o)
  );

endmodule

// File: rtl/emb_checker.sv
module emb_checker
  import emb_pkg::*;
#(
  parameter int  RGB_W  = 18,
  localparam int WORD_W = RGB_W + CTL_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_i,
  input logic              de_i,
  input logic              hsync_i,
  input logic              vsync_i,
  input logic [RGB_W-1:0]  rgb_i,
  input logic [1:0]        aux_i,
  input logic              aud_valid_i,
  input logic              aud_sd_i,
  input logic              aud_ws_i,
  input logic              aud_ready_o,
  input logic [WORD_W-1:0] word_o
);

  localparam int B_VS  = RGB_W + C_VS;
  localparam int B_DE  = RGB_W + C_DE;
  localparam int B_SD  = RGB_W + C_SD;
  localparam int B_WS  = RGB_W + C_WS;
  localparam int B_SCK = RGB_W + C_SCK;
  localparam int B_CSN = RGB_W + C_CSN;
  localparam int B_AX0 = RGB_W + C_AUX0;
  localparam int B_AX1 = RGB_W + C_AUX1;

  AST_RGB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    de_i |=> word_o[RGB_W-1:0] == $past(rgb_i)); // R1
  AST_RGB_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    !word_o[B_DE] |-> word_o[RGB_W-1:0] == '0); // R1
  AST_SYNC_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> word_o[B_DE:B_VS] == $past({de_i, hsync_i, vsync_i})); // R2
  AST_AUX_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> word_o[B_AX1:B_AX0] == $past(aux_i)); // R3
  AST_NO_READY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    de_i |-> !aud_ready_o); // R4
  AST_RAW_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && aud_valid_i && aud_ready_o) |=>
      (!word_o[B_CSN] && word_o[B_WS:B_SD] == $past({aud_ws_i, aud_sd_i}))); // R5
  AST_RAW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i && !(aud_valid_i && aud_ready_o)) |=>
      (word_o[B_CSN] && !word_o[B_SCK] && $stable(word_o[B_WS:B_SD]))); // R6
  AST_DATA_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_o[B_WS:B_SD]) |-> !word_o[B_SCK]); // R8
  AST_CMP_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i |=> !word_o[B_CSN]); // R9
  AST_CLK_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i && de_i) |=> $stable(word_o[B_SCK])); // R12

endmodule

bind blank_audio_embedder emb_checker #(.RGB_W(RGB_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .mode_i      (mode_i),
  .de_i        (de_i),
  .hsync_i     (hsync_i),
  .vsync_i     (vsync_i),
  .rgb_i       (rgb_i),
  .aux_i       (aux_i),
  .aud_valid_i (aud_valid_i),
  .aud_sd_i    (aud_sd_i),
  .aud_ws_i    (aud_ws_i),
  .aud_ready_o (aud_ready_o),
  .word_o      (word_o)
);

// File: tb/tb_blank_audio_embedder.sv
module tb_blank_audio_embedder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_i;
  logic [1:0]  div_sel_i;
  logic        vsync_i, hsync_i, de_i;
  logic [17:0] rgb_i;
  logic [1:0]  aux_i;
  logic        aud_valid_i, aud_sd_i, aud_ws_i;
  logic        aud_ready_o;
  logic [26:0] word_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blank_audio_embedder dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .div_sel_i   (div_sel_i),
    .vsync_i     (vsync_i),
    .hsync_i     (hsync_i),
    .de_i        (de_i),
    .rgb_i       (rgb_i),
    .aux_i       (aux_i),
    .aud_valid_i (aud_valid_i),
    .aud_sd_i    (aud_sd_i),
    .aud_ws_i    (aud_ws_i),
    .aud_ready_o (aud_ready_o),
    .word_o      (word_o)
  );

  // fields: de, hs, vs, rgb, aux, valid, sd, ws, exp_ready, exp_sd, exp_ws, exp_cs_n
  typedef struct packed {
    logic        de;
    logic        hs;
    logic        vs;
    logic [17:0] rgb;
    logic [1:0]  aux;
    logic        valid;
    logic        sd;
    logic        ws;
    logic        e_rdy;
    logic        e_sd;
    logic        e_ws;
    logic        e_cs;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 1'b0, 18'h2A5C3, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b0, 18'h3FFFF, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 18'h12345, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b0, 1'b1, 18'h00000, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 18'h15555, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{1'b1, 1'b0, 1'b0, 18'h0F0F0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{1'b1, 1'b1, 1'b1, 18'h00001, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    '{1'b0, 1'b0, 1'b0, 18'h3C3C3, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [26:0] exp_word(input vec_t v);
    return {v.aux[1], v.aux[0], v.e_cs, 1'b0, v.e_ws, v.e_sd,
            v.de, v.hs, v.vs, (v.de ? v.rgb : 18'h0)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one blanking/active cycle with only the audio side driven
  task automatic step(input logic d, input logic v, input logic s,
                      output logic r, output logic [26:0] w);
    de_i        = d;
    aud_valid_i = v;
    aud_sd_i    = s;
    aud_ws_i    = ~s;
    #1;
    r = aud_ready_o;
    @(negedge clk);
    w = word_o;
  endtask

  // compressed-mode stream of n bits offered back to back
  task automatic run_cmp(input logic [1:0] sel, input int n, input logic [7:0] pat,
                         input int expn);
    int          sent = 0;
    int          rises = 0;
    int          last_rise = -1;
    int          bad_period = 0;
    int          bad_stab = 0;
    int          bad_cs = 0;
    logic [7:0]  got = '0;
    logic [7:0]  mask;
    logic [26:0] prev_w;
    logic [26:0] w;
    logic        r;
    prev_w = word_o;
    for (int c = 0; c < n * expn + 6; c++) begin
      div_sel_i = sel;
      step(1'b0, (sent < n), pat[sent % 8], r, w);
      if (r && (sent < n)) sent++;
      if (w[23] && !prev_w[23]) begin
        if (rises < 8) got[rises] = w[21];
        if (last_rise >= 0 && (c - last_rise) != expn) bad_period++;
        last_rise = c;
        rises++;
      end
      if (w[23] && (w[22:21] != prev_w[22:21])) bad_stab++;
      if (w[24]) bad_cs++;
      prev_w = w;
    end
    mask = (8'd1 << n) - 8'd1;
    chk(rises == n, "R7 rising edge count", rises, n);
    chk(((got ^ pat) & mask) == 8'h0, "R7 bits at rising edges", got & mask, pat & mask);
    chk(bad_period == 0, "R7 bit-clock period", bad_period, 0);
    chk(bad_stab == 0, "R8 data change while clock high", bad_stab, 0);
    chk(bad_cs == 0, "R9 chip select low in compressed mode", bad_cs, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic        r;
    logic [26:0] w;
    logic [11:0] sck_seq;
    int          hi_cnt;
    int          bad;

    rst_n = 1'b0; mode_i = 1'b0; div_sel_i = 2'd0;
    vsync_i = 1'b0; hsync_i = 1'b0; de_i = 1'b1; rgb_i = '0; aux_i = '0;
    aud_valid_i = 1'b0; aud_sd_i = 1'b0; aud_ws_i = 1'b0;

    repeat (3) @(negedge clk);
    chk(word_o == 27'h1000000, "R11 reset word", word_o, 27'h1000000);
    chk(aud_ready_o == 1'b0, "R11 reset ready", aud_ready_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // raw-mode vector table: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      de_i = VECS[i].de; hsync_i = VECS[i].hs; vsync_i = VECS[i].vs;
      rgb_i = VECS[i].rgb; aux_i = VECS[i].aux;
      aud_valid_i = VECS[i].valid; aud_sd_i = VECS[i].sd; aud_ws_i = VECS[i].ws;
      #1;
      chk(aud_ready_o == VECS[i].e_rdy, "R4/R5 ready in raw mode", aud_ready_o, VECS[i].e_rdy);
      @(negedge clk);
      chk(word_o == exp_word(VECS[i]), "R1/R2/R3/R5/R6 raw word", word_o, exp_word(VECS[i]));
    end
    hsync_i = 1'b0; vsync_i = 1'b0; aux_i = '0; rgb_i = '0;

    // compressed mode, each divide select: R7 R8 R9
    mode_i = 1'b1;
    run_cmp(2'd0, 4, 8'b0000_1011, 2);
    run_cmp(2'd1, 4, 8'b0000_0110, 4);
    run_cmp(2'd2, 3, 8'b0000_0101, 8);
    run_cmp(2'd3, 3, 8'b0000_0011, 8);

    // R9: nothing offered at a boundary keeps the clock low and ready high
    bad = 0;
    for (int c = 0; c < 6; c++) begin
      step(1'b0, 1'b0, 1'b0, r, w);
      if (w[23] || !r) bad++;
    end
    chk(bad == 0, "R9 idle clock low and ready high", bad, 0);

    // R12: active video inside an 8-cycle period freezes it
    div_sel_i = 2'd2;
    sck_seq = '0;
    bad = 0;
    for (int c = 0; c < 12; c++) begin
      step((c >= 5 && c <= 7), (c == 0), 1'b1, r, w);
      sck_seq[c] = w[23];
      if (c >= 5 && c <= 7 && r) bad++;
    end
    chk(sck_seq == 12'h7F0, "R12 bit clock frozen across active video", sck_seq, 12'h7F0);
    chk(bad == 0, "R4 no ready during active video", bad, 0);

    // R10: divide change in mid-period waits for the next period
    hi_cnt = 0;
    for (int c = 0; c < 12; c++) begin
      div_sel_i = (c == 0) ? 2'd2 : 2'd0;
      step(1'b0, (c == 0), 1'b0, r, w);
      if (w[23]) hi_cnt++;
    end
    chk(hi_cnt == 4, "R10 period kept after mid-period change", hi_cnt, 4);
    run_cmp(2'd0, 3, 8'b0000_0010, 2);

    // R11: reset asserted during operation
    step(1'b0, 1'b1, 1'b1, r, w);
    rst_n = 1'b0;
    #1;
    chk(word_o == 27'h1000000, "R11 word after reset", word_o, 27'h1000000);
    chk(aud_ready_o == 1'b0, "R11 ready after reset", aud_ready_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule